// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This block turns an indexed-addressing postbyte, plus the zero, one or two extension bytes that follow it in a byte-wide instruction stream, into a 16-bit effective address. The postbyte picks a base register (X, Y, SP or PC) and one of several offset forms: a short signed constant held in the postbyte itself, a 9-bit or 16-bit signed constant from the extension bytes, an accumulator offset, or an auto-modify step of +1..+8 or -1..-8 applied before or after use. Two forms are indirect: the computed address points at a 16-bit pointer in memory, fetched high byte first over a byte-wide request/acknowledge port, and the pointer becomes the result.

The surrounding core pulses `start` with the postbyte, supplies the current register and accumulator values, feeds extension bytes when `ext_ready` is high, and answers memory reads. On completion the unit raises `done` for one cycle with the address, the number of extension bytes it consumed and, for auto-modify forms, the new base value and which register to write back.

Control is a six-state machine. **S_IDLE** waits for `start`; on it the decoded postbyte, the selected base and the initial offset are captured. Transitions out of S_IDLE: to **S_EXT_A** when any extension byte is needed, to **S_PTR_HI** for the accumulator-D indirect form, otherwise to **S_DONE**. **S_EXT_A** takes the first extension byte, going to **S_DONE** for the 9-bit form or **S_EXT_B** for 16-bit forms. **S_EXT_B** takes the low byte, going to **S_PTR_HI** when indirect, else to **S_DONE**. **S_PTR_HI** reads the pointer high byte and on acknowledge moves to **S_PTR_LO**, which reads the low byte at the next address and moves to **S_DONE**. **S_DONE** presents the result for one cycle and returns to **S_IDLE**.

Top module: `idx_ea_unit`

## Requirements
- R1: The register field selects the base as 00 = X, 01 = Y, 10 = SP, 11 = PC; the field is postbyte bits 7:6 when bit 5 is 0 or bits 7:5 are not 111, and bits 4:3 when bits 7:5 are 111.
- R2: A postbyte with bit 5 = 0 uses bits 4:0 as a signed offset (-16..+15), consumes no extension byte and gives EA = base + offset.
- R3: A postbyte 111rr00s consumes one extension byte; the offset is that byte sign-extended with bit 0 (s) as the sign, so the offset is {8 copies of s, byte}.
- R4: A postbyte 111rr010 consumes two extension bytes, the first being the high byte of a 16-bit offset; EA = base + offset.
- R5: A postbyte 111rr011 consumes two extension bytes as in R4, then reads the byte at P = base + offset and the byte at P + 1; EA = {byte at P, byte at P + 1}.
- R6: A postbyte with bits 7:5 other than 111 and bit 5 = 1 is auto-modify: bit 4 = 0 gives EA = base + step, bit 4 = 1 gives EA = base; in both cases wb_en is high with done, wb_value = base + step and wb_sel = bits 7:6. No extension byte is consumed.
- R7: The auto-modify step from bits 3:0 is value + 1 for 0000..0111 (+1..+8) and the 4-bit two's complement value for 1000..1111 (-8..-1).
- R8: PC is never auto-modified: wb_en is never high with wb_sel = 11, because any postbyte with bits 7:5 = 111 decodes as a constant or accumulator form.
- R9: A postbyte 111rr1aa with aa = 00 adds A zero-extended, aa = 01 adds B zero-extended, aa = 10 adds D = {A, B}; no extension byte is consumed.
- R10: A postbyte 111rr111 reads a pointer at base + D as in R5 and returns it as EA, with no extension byte consumed.
- R11: All address sums, including P + 1, wrap modulo 2^16.
- R12: done is a single-cycle pulse; wb_en is low unless the form is auto-modify; no memory read is issued for non-indirect forms; mem_req and mem_addr hold steady until mem_ack; start is ignored while an operation is in progress.
- R13: After reset the unit is idle with done, wb_en, mem_req and ext_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with `postbyte` (taken only when idle) |
| postbyte | input | 8 | Indexed postbyte |
| ext_valid | input | 1 | Extension byte present |
| ext_byte | input | 8 | Extension byte from the instruction stream |
| ext_ready | output | 1 | Unit is waiting for an extension byte |
| x_val | input | 16 | X register value |
| y_val | input | 16 | Y register value |
| sp_val | input | 16 | SP register value |
| pc_val | input | 16 | PC value used as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result valid (one cycle) |
| ea | output | 16 | Effective address |
| ext_count | output | 2 | Extension bytes consumed |
| wb_en | output | 1 | Base write-back strobe |
| wb_sel | output | 2 | Register to write back (00 X, 01 Y, 10 SP) |
| wb_value | output | 16 | Modified base value |

## Verification
The hardest situation to reach is an indirect fetch whose pointer straddles the top of the address space while both the extension-byte source and the memory port stall at random, since the second read must keep its incremented, wrapped address across any number of idle cycles. The bench drives a directed indirect case with base and offset summing to FFFF and lets its byte feeder and memory responder withhold `ext_valid` and `mem_ack` at random, while several hundred random postbytes with random register values cover every form under the same stalls. A start pulse issued in the middle of an indirect fetch checks that a busy unit ignores new work.

// File: rtl/idx_pkg.sv
package idx_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned RSEL_W = 2;

    typedef enum logic [2:0] {
        AM_K5,
        AM_K9,
        AM_K16,
        AM_AUTO,
        AM_ACC
    } am_t;

    typedef struct packed {
        am_t               am;
        logic [RSEL_W-1:0] rsel;
        logic [1:0]        n_ext;
        logic              ind;
        logic              pre;
        logic              sgn9;
        logic [1:0]        acc_sel;
        logic [ADDR_W-1:0] imm;
    } dec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EXT_A,
        S_EXT_B,
        S_PTR_HI,
        S_PTR_LO,
        S_DONE
    } st_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_pkg::*;
(
    input  logic [BYTE_W-1:0] pb,
    output dec_t              dec
);
    localparam int unsigned K5_W   = 5;
    localparam int unsigned STEP_W = 4;

    always_comb begin
        dec = '0;
        dec.am = AM_K5;
        if (!pb[5]) begin
            // short constant, sign in bit 4
            dec.am   = AM_K5;
            dec.rsel = pb[7:6];
            dec.imm  = {{(ADDR_W-K5_W){pb[4]}}, pb[K5_W-1:0]};
        end else if (pb[7:5] != 3'b111) begin
            // auto-modify: biased step code
            dec.am   = AM_AUTO;
            dec.rsel = pb[7:6];
            dec.pre  = ~pb[4];
            if (pb[3])
                dec.imm = {{(ADDR_W-STEP_W){1'b1}}, pb[STEP_W-1:0]};
            else
                dec.imm = {{(ADDR_W-STEP_W){1'b0}}, pb[STEP_W-1:0]} + 16'd1;
        end else begin
            dec.rsel = pb[4:3];
            if (!pb[2]) begin
                if (!pb[1]) begin
                    dec.am    = AM_K9;
                    dec.n_ext = 2'd1;
                    dec.sgn9  = pb[0];
                end else begin
                    dec.am    = AM_K16;
                    dec.n_ext = 2'd2;
                    dec.ind   = pb[0];
                end
            end else begin
                dec.am      = AM_ACC;
                dec.acc_sel = pb[1:0];
                dec.ind     = (pb[1:0] == 2'b11);
            end
        end
    end

    // R8: only auto-modify can request a write-back, and never toward PC
    always_comb begin
        if (dec.am == AM_AUTO)
            assert (dec.rsel != 2'b11) else $error("p_auto_not_pc_r8");
    end
endmodule

// File: rtl/idx_operand.sv
module idx_operand
    import idx_pkg::*;
(
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] x_val,
    input  logic [ADDR_W-1:0] y_val,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] off_init
);
    localparam int unsigned NREG = 1 << RSEL_W;

    logic [ADDR_W-1:0] bank [NREG];
    logic [ADDR_W-1:0] acc_off;

    assign bank[0] = x_val;
    assign bank[1] = y_val;
    assign bank[2] = sp_val;
    assign bank[3] = pc_val;

    assign base = bank[dec.rsel];

    always_comb begin
        unique case (dec.acc_sel)
            2'b00:   acc_off = {{(ADDR_W-BYTE_W){1'b0}}, acc_a};
            2'b01:   acc_off = {{(ADDR_W-BYTE_W){1'b0}}, acc_b};
            default: acc_off = {acc_a, acc_b};
        endcase
    end

    assign off_init = (dec.am == AM_ACC) ? acc_off : dec.imm;
endmodule

// File: rtl/idx_fsm.sv
module idx_fsm
    import idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dec_t              dec,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] off_init,
    input  logic              ext_valid,
    input  logic [BYTE_W-1:0] ext_byte,
    output logic              ext_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [1:0]        ext_count,
    output logic              wb_en,
    output logic [RSEL_W-1:0] wb_sel,
    output logic [ADDR_W-1:0] wb_value
);
    st_t               state, nstate;
    dec_t              dec_q;
    logic [ADDR_W-1:0] base_q, off_q, ptr_q;
    logic [BYTE_W-1:0] hi_q;
    logic [ADDR_W-1:0] sum;

    assign sum = base_q + off_q;

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (dec.n_ext != 2'd0) nstate = S_EXT_A;
                    else if (dec.ind)      nstate = S_PTR_HI;
                    else                   nstate = S_DONE;
                end
            end
            S_EXT_A: begin
                if (ext_valid)
                    nstate = (dec_q.n_ext == 2'd1) ? S_DONE : S_EXT_B;
            end
            S_EXT_B: begin
                if (ext_valid)
                    nstate = dec_q.ind ? S_PTR_HI : S_DONE;
            end
            S_PTR_HI: if (mem_ack) nstate = S_PTR_LO;
            S_PTR_LO: if (mem_ack) nstate = S_DONE;
            S_DONE:   nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            dec_q  <= '0;
            base_q <= '0;
            off_q  <= '0;
            ptr_q  <= '0;
            hi_q   <= '0;
        end else begin
            state <= nstate;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        dec_q  <= dec;
                        base_q <= base;
                        off_q  <= off_init;
                    end
                end
                S_EXT_A: begin
                    if (ext_valid) begin
                        if (dec_q.n_ext == 2'd1)
                            off_q <= {{(ADDR_W-BYTE_W){dec_q.sgn9}}, ext_byte};
                        else
                            off_q[ADDR_W-1:BYTE_W] <= ext_byte;
                    end
                end
                S_EXT_B: if (ext_valid) off_q[BYTE_W-1:0] <= ext_byte;
                S_PTR_HI: if (mem_ack) hi_q <= mem_rdata;
                S_PTR_LO: if (mem_ack) ptr_q <= {hi_q, mem_rdata};
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ext_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        done      = 1'b0;
        ea        = '0;
        ext_count = '0;
        wb_en     = 1'b0;
        wb_sel    = '0;
        wb_value  = '0;
        unique case (state)
            S_EXT_A, S_EXT_B: ext_ready = 1'b1;
            S_PTR_HI: begin
                mem_req  = 1'b1;
                mem_addr = sum;
            end
            S_PTR_LO: begin
                mem_req  = 1'b1;
                mem_addr = sum + 16'd1;
            end
            S_DONE: begin
                done      = 1'b1;
                ext_count = dec_q.n_ext;
                if (dec_q.ind)
                    ea = ptr_q;
                else if (dec_q.am == AM_AUTO && !dec_q.pre)
                    ea = base_q;
                else
                    ea = sum;
                if (dec_q.am == AM_AUTO) begin
                    wb_en    = 1'b1;
                    wb_sel   = dec_q.rsel;
                    wb_value = sum;
                end
            end
            default: ;
        endcase
    end

    // R12: done lasts one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: a pending read holds request and address until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5 / R11: the low pointer byte is read at the next (wrapping) address
    p_lo_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR_HI && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + 16'd1));

    // R8: write-back never targets PC and only appears with done
    p_no_pc_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && wb_sel != 2'b11));

    // R12: no memory traffic while waiting for stream bytes
    p_ext_no_mem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ready |-> !mem_req);

    // R12: a start pulse mid-operation does not restart the sequence
    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_EXT_B && !ext_valid) |=> (state == S_EXT_B));
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
    import idx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  postbyte,
    input  logic        ext_valid,
    input  logic [7:0]  ext_byte,
    output logic        ext_ready,
    input  logic [15:0] x_val,
    input  logic [15:0] y_val,
    input  logic [15:0] sp_val,
    input  logic [15:0] pc_val,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    output logic        done,
    output logic [15:0] ea,
    output logic [1:0]  ext_count,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_value
);
    dec_t              dec;
    logic [ADDR_W-1:0] base, off_init;

    idx_decode u_decode (
        .pb  (postbyte),
        .dec (dec)
    );

    idx_operand u_operand (
        .dec      (dec),
        .x_val    (x_val),
        .y_val    (y_val),
        .sp_val   (sp_val),
        .pc_val   (pc_val),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .base     (base),
        .off_init (off_init)
    );

    idx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec       (dec),
        .base      (base),
        .off_init  (off_init),
        .ext_valid (ext_valid),
        .ext_byte  (ext_byte),
        .ext_ready (ext_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .ea        (ea),
        .ext_count (ext_count),
        .wb_en     (wb_en),
        .wb_sel    (wb_sel),
        .wb_value  (wb_value)
    );
endmodule

// File: tb/idx_ea_unit_tb_top.sv
module idx_ea_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_byte = '0;
    logic        ext_ready;
    logic [15:0] x_val = '0, y_val = '0, sp_val = '0, pc_val = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] ea;
    logic [1:0]  ext_count;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_value;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] ext_q [2];
    int         ext_idx = 0;
    int         rd_cnt = 0;
    logic       stall_en = 1'b1;

    always #2 clk = ~clk;

    idx_ea_unit dut_i (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'(a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
    endfunction

    // byte-stream feeder with random stalls
    always @(negedge clk) begin
        ext_valid <= ext_ready && (!stall_en || ($urandom % 4 != 0));
        ext_byte  <= ext_q[ext_idx[0]];
    end
    always @(posedge clk) if (ext_ready && ext_valid) ext_idx <= ext_idx + 1;

    // memory responder with random wait cycles
    always @(negedge clk) begin
        mem_ack   <= mem_req && (!stall_en || ($urandom % 3 != 0));
        mem_rdata <= mem_byte(mem_addr);
    end
    always @(posedge clk) if (mem_req && mem_ack) rd_cnt <= rd_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model built from the requirement text
    task automatic ref_model(input logic [7:0] pb, input logic [7:0] e1, input logic [7:0] e2,
                             output logic [15:0] x_ea, output int x_n, output bit x_wb,
                             output logic [1:0] x_sel, output logic [15:0] x_wbv,
                             output int x_rd, output string tag);
        logic [1:0]  rr;
        logic [15:0] b, off, p, step;
        bit ind;
        ind = 0; x_wb = 0; x_wbv = '0; x_n = 0; off = '0; x_sel = '0;
        if (pb[5] == 1'b0) begin
            rr = pb[7:6]; off = {{11{pb[4]}}, pb[4:0]}; tag = "R2";
        end else if (pb[7:5] != 3'b111) begin
            rr = pb[7:6]; tag = "R6";
        end else begin
            rr = pb[4:3];
            if (pb[2] == 1'b0) begin
                if (pb[1] == 1'b0) begin
                    x_n = 1; off = {{8{pb[0]}}, e1}; tag = "R3";
                end else begin
                    x_n = 2; off = {e1, e2}; ind = pb[0]; tag = pb[0] ? "R5" : "R4";
                end
            end else begin
                case (pb[1:0])
                    2'b00: off = {8'h00, acc_a};
                    2'b01: off = {8'h00, acc_b};
                    default: off = {acc_a, acc_b};
                endcase
                ind = (pb[1:0] == 2'b11); tag = ind ? "R10" : "R9";
            end
        end
        // R1: register map
        case (rr)
            2'b00: b = x_val;
            2'b01: b = y_val;
            2'b10: b = sp_val;
            default: b = pc_val;
        endcase
        if (tag == "R6") begin
            // R7: biased step code
            step = pb[3] ? (16'hFFF0 | {12'h000, pb[3:0]}) : {12'h000, pb[3:0]} + 16'd1;
            x_wb = 1; x_sel = rr; x_wbv = b + step;
            x_ea = pb[4] ? b : b + step;
        end else begin
            x_ea = b + off;
        end
        x_rd = 0;
        if (ind) begin
            p = x_ea;
            x_ea = {mem_byte(p), mem_byte(p + 16'd1)};
            x_rd = 2;
        end
    endtask

    task automatic run_op(input logic [7:0] pb, input logic [7:0] e1, input logic [7:0] e2, input bit poke_busy);
        logic [15:0] x_ea, x_wbv;
        int x_n, x_rd, guard;
        bit x_wb;
        logic [1:0] x_sel;
        string tag;
        ref_model(pb, e1, e2, x_ea, x_n, x_wb, x_sel, x_wbv, x_rd, tag);
        ext_q[0] = e1; ext_q[1] = e2;
        @(negedge clk);
        ext_idx = 0; rd_cnt = 0;
        postbyte = pb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 300) begin
            if (poke_busy && guard == 1) begin
                // R12: start while busy must be ignored
                postbyte = 8'h05; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk(done, {tag, " done seen"}, 32'(done), 1);
        if (done) begin
            chk(ea == x_ea, {tag, " R1 R11 ea"}, 32'(ea), 32'(x_ea));
            chk(int'(ext_count) == x_n, {tag, " ext_count"}, 32'(ext_count), 32'(x_n));
            chk(ext_idx == x_n, {tag, " bytes consumed"}, 32'(ext_idx), 32'(x_n));
            chk(rd_cnt == x_rd, {tag, " R12 reads issued"}, 32'(rd_cnt), 32'(x_rd));
            chk(wb_en == x_wb, {tag, " R12 wb_en"}, 32'(wb_en), 32'(x_wb));
            if (x_wb) begin
                chk(wb_value == x_wbv, "R6 R7 wb_value", 32'(wb_value), 32'(x_wbv));
                chk(wb_sel == x_sel, "R6 R8 wb_sel", 32'(wb_sel), 32'(x_sel));
            end
            @(negedge clk);
            chk(!done, "R12 done pulse width", 32'(done), 0);
        end
    endtask

    task automatic rand_regs();
        x_val = 16'($urandom); y_val = 16'($urandom);
        sp_val = 16'($urandom); pc_val = 16'($urandom);
        acc_a = 8'($urandom); acc_b = 8'($urandom);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h51C0_0DE5);
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!done && !wb_en && !mem_req && !ext_ready, "R13 reset idle",
            {28'd0, done, wb_en, mem_req, ext_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        x_val = 16'h1000; y_val = 16'h2000; sp_val = 16'h3000; pc_val = 16'h4000;
        acc_a = 8'h12; acc_b = 8'h34;
        run_op(8'b00_0_01111, 8'h00, 8'h00, 0);       // R2 X + 15
        run_op(8'b01_0_10000, 8'h00, 8'h00, 0);       // R2 Y - 16
        run_op(8'b11_0_00001, 8'h00, 8'h00, 0);       // R1 PC + 1
        run_op(8'b111_10_001, 8'h80, 8'h00, 0);       // R3 SP - 128
        run_op(8'b111_01_000, 8'hFF, 8'h00, 0);       // R3 +255
        run_op(8'b111_00_010, 8'hAB, 8'hCD, 0);       // R4 hi first
        run_op(8'b00_1_0_0111, 8'h00, 8'h00, 0);      // R6 R7 pre +8
        run_op(8'b01_1_1_1000, 8'h00, 8'h00, 0);      // R6 R7 post -8
        run_op(8'b10_1_1_1111, 8'h00, 8'h00, 0);      // R7 post -1
        run_op(8'b111_00_100, 8'h00, 8'h00, 0);       // R9 A
        run_op(8'b111_01_101, 8'h00, 8'h00, 0);       // R9 B
        run_op(8'b111_10_110, 8'h00, 8'h00, 0);       // R9 D
        run_op(8'b111_11_111, 8'h00, 8'h00, 0);       // R10 D indirect
        // R11: wrap cases
        x_val = 16'hFFF0;
        run_op(8'b111_00_010, 8'h00, 8'h20, 0);
        run_op(8'b111_00_011, 8'h00, 8'h0F, 0);       // R5 pointer at FFFF / 0000
        x_val = 16'hFFFF;
        run_op(8'b00_1_1_0000, 8'h00, 8'h00, 0);      // post +1 wraps write-back
        // R12: start while busy
        y_val = 16'h0200;
        run_op(8'b111_01_011, 8'h01, 8'h02, 1);
        stall_en = 1'b0;
        run_op(8'b111_00_011, 8'h12, 8'h34, 0);       // R5 without stalls
        stall_en = 1'b1;

        for (int i = 0; i < 400; i++) begin
            rand_regs();
            run_op(8'($urandom), 8'($urandom), 8'($urandom), (i % 17) == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule